// File: doc/BRIEF.md
# Effective Address Generator

This unit turns an operand addressing request into a 16-bit effective address. A request carries a 4-bit mode code, a 16-bit operand field (only the low byte counts for the byte-wide modes) and two 8-bit index values, X and Y. The request is taken on a one-cycle `start` pulse. The unit answers with a one-cycle `done` pulse that carries either the address or an error flag.

Direct modes are computed arithmetically and need no memory. The three indirect modes fetch a two-byte pointer through a single-byte read port. Each read is a one-cycle request, and its data is sampled one cycle later. Every address placed on that read port is first folded by a two-region mirroring map.

Instruction fetch, the final operand access and cycle penalties for crossing a page are handled elsewhere. `effAddr` is the unfolded logical address, and the consumer applies its own mapping.

Top module: `ea_gen`

## Requirements
- R1: Mode codes are 1 = byte-page, 2 = byte-page+X and 3 = byte-page+Y. For these modes the result is `{8'h00, (operand[7:0] + index) mod 256}`, with index 0 for code 1. The result never leaves page zero, whatever `operand[15:8]` holds.
- R2: Mode codes are 5 = full address, 6 = full+X and 7 = full+Y. The result is `(operand + index) mod 65536`, with index 0 for code 5.
- R3: Modes 1, 2, 3, 5, 6 and 7 assert `done` in the cycle after the edge that samples `start`, and they never raise `memReq`.
- R4: Mode 9 (pre-indexed) reads the pointer low byte at `(operand[7:0]+X) mod 256` and the high byte at `(operand[7:0]+X+1) mod 256`. The result is `high*256 + low`.
- R5: Mode 10 (post-indexed) reads the low byte at `operand[7:0]` and the high byte at `(operand[7:0]+1) mod 256`. The result is `(high*256 + low + Y) mod 65536`.
- R6: Mode 8 (plain indirect) reads the low byte at `operand` and the high byte at `(operand+1) mod 65536`. The result is `high*256 + low`.
- R7: Pointer reads are ordered low byte first, then high byte. Each read is a `memReq` pulse lasting exactly one cycle, and `memData` is sampled in the following cycle. `done` rises after the fifth rising edge, counting the edge that samples `start`, and it is never high together with `memReq`.
- R8: Every `memAddr` is folded before it is issued. Below 0x2000 it is ANDed with 0x07FF. From 0x2000 to 0x3FFF it is ANDed with 0x2007. Any other address passes unchanged.
- R9: Mode 0, mode 4 and the unused codes 11 to 15 produce `done` with `error` set and `effAddr` = 0, one cycle after `start`, with no memory read.
- R10: A `start` pulse that arrives while an indirect request is in progress is ignored. It produces no extra `done`, and the running request still completes correctly.
- R11: While reset (`rstN` low) is held, `done`, `error` and `memReq` are 0 and `effAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| mode | input | 4 | Addressing mode code |
| operand | input | 16 | Operand field; byte modes use bits 7:0 |
| idxX | input | 8 | X index value |
| idxY | input | 8 | Y index value |
| memReq | output | 1 | Pointer byte read request |
| memAddr | output | 16 | Folded read address |
| memData | input | 8 | Read data, valid the cycle after `memReq` |
| done | output | 1 | Result strobe |
| error | output | 1 | Request had no address (valid with `done`) |
| effAddr | output | 16 | Effective address (valid with `done`) |

## Verification
Each mode is driven with an index sum that stays inside its range and with one that overflows. This separates a wrap at 8 bits from a wrap at 16 bits, and it shows that a junk upper operand byte is discarded. For the indirect modes, pointers are placed at 0xFF and 0x00 to expose a high-byte fetch that escapes page zero. The plain indirect mode is given operands in both folded regions and in the pass-through region, and the bench checks the read address sequence against its own folding model. The bench also gives error codes, both defined and unused, and sends a stray start pulse while an indirect request is busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [3:0] MODE_IMM  = 4'd0;
  localparam logic [3:0] MODE_ZP   = 4'd1;
  localparam logic [3:0] MODE_ZPX  = 4'd2;
  localparam logic [3:0] MODE_ZPY  = 4'd3;
  localparam logic [3:0] MODE_REL  = 4'd4;
  localparam logic [3:0] MODE_ABS  = 4'd5;
  localparam logic [3:0] MODE_ABSX = 4'd6;
  localparam logic [3:0] MODE_ABSY = 4'd7;
  localparam logic [3:0] MODE_IND  = 4'd8;
  localparam logic [3:0] MODE_INDX = 4'd9;
  localparam logic [3:0] MODE_INDY = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQLO, ST_WAITLO, ST_REQHI, ST_WAITHI
  } eaState_t;

  typedef struct packed {
    logic capture;   // latch request for an indirect walk
    logic reqLo;     // issue pointer low-byte read
    logic reqHi;     // issue pointer high-byte read
    logic takeLo;    // store returned low byte
    logic finInd;    // finish indirect request
    logic finDir;    // finish direct request
    logic finErr;    // finish with error
  } eaStrobe_t;

  function automatic logic modeIsDirect(input logic [3:0] m);
    return (m == MODE_ZP) || (m == MODE_ZPX) || (m == MODE_ZPY) ||
           (m == MODE_ABS) || (m == MODE_ABSX) || (m == MODE_ABSY);
  endfunction

  function automatic logic modeIsIndirect(input logic [3:0] m);
    return (m == MODE_IND) || (m == MODE_INDX) || (m == MODE_INDY);
  endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output eaStrobe_t  strobe
);

  eaState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (modeIsIndirect(mode)) begin
            strobe.capture = 1'b1;
            stateNext      = ST_REQLO;
          end else if (modeIsDirect(mode)) begin
            strobe.finDir = 1'b1;
          end else begin
            strobe.finErr = 1'b1;
          end
        end
      end
      ST_REQLO: begin
        strobe.reqLo = 1'b1;
        stateNext    = ST_WAITLO;
      end
      ST_WAITLO: begin
        strobe.takeLo = 1'b1;
        stateNext     = ST_REQHI;
      end
      ST_REQHI: begin
        strobe.reqHi = 1'b1;
        stateNext    = ST_WAITHI;
      end
      ST_WAITHI: begin
        strobe.finInd = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] FOLD_LO_END  = 16'h2000,
  parameter logic [2*DW-1:0] FOLD_LO_MASK = 16'h07FF,
  parameter logic [2*DW-1:0] FOLD_HI_END  = 16'h4000,
  parameter logic [2*DW-1:0] FOLD_HI_MASK = 16'h2007,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  eaStrobe_t     strobe,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] operand,
  input  logic [DW-1:0] idxX,
  input  logic [DW-1:0] idxY,
  input  logic [DW-1:0] memData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] effAddr
);

  logic [3:0]    modeQ;
  logic [AW-1:0] opQ;
  logic [DW-1:0] xQ, yQ, lowQ;
  logic [DW-1:0] zpIdxLo, zpIdxHi, zpPlainHi;
  logic [AW-1:0] ptrLo, ptrHi, dirAddr, indAddr, rawRead;

  function automatic logic [AW-1:0] foldAddr(input logic [AW-1:0] a);
    if (a < FOLD_LO_END)      return a & FOLD_LO_MASK;
    else if (a < FOLD_HI_END) return a & FOLD_HI_MASK;
    else                      return a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      opQ   <= '0;
      xQ    <= '0;
      yQ    <= '0;
    end else if (strobe.capture) begin
      modeQ <= mode;
      opQ   <= operand;
      xQ    <= idxX;
      yQ    <= idxY;
    end
  end

  // pointer byte addresses; byte-page variants wrap at DW bits
  always_comb begin
    zpIdxLo   = opQ[DW-1:0] + xQ;
    zpIdxHi   = zpIdxLo + 1'b1;
    zpPlainHi = opQ[DW-1:0] + 1'b1;
    case (modeQ)
      MODE_INDX: begin
        ptrLo = {{DW{1'b0}}, zpIdxLo};
        ptrHi = {{DW{1'b0}}, zpIdxHi};
      end
      MODE_INDY: begin
        ptrLo = {{DW{1'b0}}, opQ[DW-1:0]};
        ptrHi = {{DW{1'b0}}, zpPlainHi};
      end
      default: begin
        ptrLo = opQ;
        ptrHi = opQ + 1'b1;
      end
    endcase
  end

  assign rawRead = strobe.reqLo ? ptrLo : ptrHi;
  assign memReq  = strobe.reqLo | strobe.reqHi;
  assign memAddr = memReq ? foldAddr(rawRead) : '0;

  // direct modes computed from the live request
  always_comb begin
    case (mode)
      MODE_ZP:   dirAddr = {{DW{1'b0}}, operand[DW-1:0]};
      MODE_ZPX:  dirAddr = {{DW{1'b0}}, operand[DW-1:0] + idxX};
      MODE_ZPY:  dirAddr = {{DW{1'b0}}, operand[DW-1:0] + idxY};
      MODE_ABSX: dirAddr = operand + {{DW{1'b0}}, idxX};
      MODE_ABSY: dirAddr = operand + {{DW{1'b0}}, idxY};
      default:   dirAddr = operand;
    endcase
  end

  assign indAddr = {memData, lowQ} +
                   ((modeQ == MODE_INDY) ? {{DW{1'b0}}, yQ} : {AW{1'b0}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ    <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      effAddr <= '0;
    end else begin
      if (strobe.takeLo) lowQ <= memData;
      done  <= strobe.finDir | strobe.finInd | strobe.finErr;
      error <= strobe.finErr;
      if (strobe.finDir)      effAddr <= dirAddr;
      else if (strobe.finInd) effAddr <= indAddr;
      else if (strobe.finErr) effAddr <= '0;
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] operand,
  input  logic [DW-1:0] idxX,
  input  logic [DW-1:0] idxY,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memData,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] effAddr
);

  eaStrobe_t strobe;

  ea_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .strobe(strobe)
  );

  ea_dpath #(.DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .operand(operand),
    .idxX(idxX), .idxY(idxY), .memData(memData), .memReq(memReq),
    .memAddr(memAddr), .done(done), .error(error), .effAddr(effAddr)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic          done,
  input logic          error,
  input logic [AW-1:0] effAddr
);

  // R7: each read request lasts a single cycle
  assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R7: result strobe never overlaps a pointer read
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R8: nothing in the lower mirrored window above its base copy
  assert_fold_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !(memAddr >= 16'h0800 && memAddr < 16'h2000));

  // R8: upper mirrored window keeps only its eight-byte image
  assert_fold_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAddr >= 16'h2000 && memAddr < 16'h4000) |->
      ((memAddr & ~16'h2007) == 16'h0000));

  // R9: error only with done and a zero address
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (done && effAddr == '0));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
  .done(done), .error(error), .effAddr(effAddr)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] operand = '0;
  logic [7:0]  idxX = '0, idxY = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic        done, error;
  logic [15:0] effAddr;

  int total = 0;
  int bad = 0;
  int expQ[$];
  int readQ[$];
  logic [7:0] memOvr [int];

  always #4 clk = ~clk;

  ea_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .operand(operand),
    .idxX(idxX), .idxY(idxY), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .done(done), .error(error), .effAddr(effAddr)
  );

  function automatic logic [7:0] rdByte(input logic [15:0] a);
    if (memOvr.exists(int'(a))) return memOvr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] refFold(input logic [15:0] a);
    if (a <= 16'h1FFF) return {5'b0, a[10:0]};
    if (a <= 16'h3FFF) return {13'b0010000000000, a[2:0]};
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and read-order monitor
  always @(negedge clk) begin
    if (rstN && memReq) begin
      memData <= rdByte(memAddr);
      if (readQ.size() == 0) check(0, "R3 unexpected read", memAddr, 0);
      else begin
        int e;
        e = readQ.pop_front();
        check(memAddr == e[15:0], "R7/R8 read address", memAddr, e);
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(0, "R10 unexpected done", effAddr, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check({error, effAddr} == e[16:0], "R1-R9 result", {error, effAddr}, e);
      end
    end
  end

  task automatic predict(input logic [3:0] m, input logic [15:0] op,
                         input logic [7:0] x, input logic [7:0] y,
                         output int lat);
    logic [15:0] pl, ph, res;
    logic [7:0]  b;
    bit ind, err;
    ind = 0; err = 0; res = 0; pl = 0; ph = 0;
    case (m)
      4'd1: res = {8'h00, op[7:0]};
      4'd2: begin b = op[7:0] + x; res = {8'h00, b}; end
      4'd3: begin b = op[7:0] + y; res = {8'h00, b}; end
      4'd5: res = op;
      4'd6: res = op + {8'h00, x};
      4'd7: res = op + {8'h00, y};
      4'd8: begin ind = 1; pl = op; ph = op + 16'd1; end
      4'd9: begin
        ind = 1; b = op[7:0] + x; pl = {8'h00, b};
        b = b + 8'd1; ph = {8'h00, b};
      end
      4'd10: begin
        ind = 1; pl = {8'h00, op[7:0]};
        b = op[7:0] + 8'd1; ph = {8'h00, b};
      end
      default: err = 1;
    endcase
    if (ind) begin
      readQ.push_back(int'(refFold(pl)));
      readQ.push_back(int'(refFold(ph)));
      res = {rdByte(refFold(ph)), rdByte(refFold(pl))};
      if (m == 4'd10) res = res + {8'h00, y};
    end
    expQ.push_back(int'({err, res}));
    lat = ind ? 5 : 1;
  endtask

  task automatic runOp(input logic [3:0] m, input logic [15:0] op,
                       input logic [7:0] x, input logic [7:0] y, input string req);
    int lat, n;
    predict(m, op, x, y, lat);
    mode = m; operand = op; idxX = x; idxY = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == lat, {req, " latency"}, n, lat);
    @(negedge clk);
    check(!done, {req, " single done"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!done && !error && !memReq && effAddr == 16'h0, "R11 reset",
          {done, error, memReq, effAddr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(4'd1, 16'hABF3, 8'h00, 8'h00, "R1 zp");
    runOp(4'd2, 16'h12F0, 8'h20, 8'h00, "R1 zpx wrap");
    runOp(4'd3, 16'h0005, 8'h77, 8'h03, "R1 zpy");
    runOp(4'd5, 16'h1234, 8'h00, 8'h00, "R2 abs");
    runOp(4'd6, 16'hFFF0, 8'h20, 8'h00, "R2 absx wrap");
    runOp(4'd7, 16'h8000, 8'h00, 8'hFF, "R2 absy");
    runOp(4'd6, 16'h80FF, 8'h01, 8'h00, "R3 absx page");

    memOvr[32'h00FF] = 8'h34;
    memOvr[32'h0000] = 8'h12;
    runOp(4'd9, 16'h00FE, 8'h01, 8'h00, "R4 indx wrap");
    runOp(4'd9, 16'h0040, 8'h10, 8'h00, "R4 indx");
    runOp(4'd10, 16'h00FF, 8'h00, 8'h10, "R5 indy wrap");
    memOvr[32'h0080] = 8'hF0;
    memOvr[32'h0081] = 8'hFF;
    runOp(4'd10, 16'h0080, 8'h00, 8'h20, "R5 indy carry");

    runOp(4'd8, 16'h2809, 8'h00, 8'h00, "R8 ind high window");
    runOp(4'd8, 16'h1800, 8'h00, 8'h00, "R8 ind low window");
    runOp(4'd8, 16'hFFFF, 8'h00, 8'h00, "R6 ind wrap");
    runOp(4'd8, 16'h5000, 8'h00, 8'h00, "R6 R8 pass");

    runOp(4'd0, 16'h1234, 8'h00, 8'h00, "R9 imm");
    runOp(4'd4, 16'h0010, 8'h00, 8'h00, "R9 rel");
    runOp(4'd11, 16'h4321, 8'h00, 8'h00, "R9 code11");
    runOp(4'd15, 16'hFFFF, 8'h01, 8'h01, "R9 code15");

    // R10: stray start during an indirect walk
    begin
      int lat, n;
      predict(4'd9, 16'h0040, 8'h05, 8'h00, lat);
      mode = 4'd9; operand = 16'h0040; idxX = 8'h05; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mode = 4'd1; operand = 16'h0099; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 3;
      while (!done && n < 40) begin @(negedge clk); n++; end
      check(n == lat, "R10 latency", n, lat);
      repeat (3) begin
        @(negedge clk);
        check(!done, "R10 no extra done", done, 0);
      end
    end

    check(expQ.size() == 0 && readQ.size() == 0, "R7 queues drained",
          expQ.size() + readQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule